// File: doc/BRIEF.md
# MSI Record Ring Logger

The block takes message-signalled interrupt writes arriving on an inbound data port and stores each one as a 16-byte record in a circular buffer in system memory. It then raises a level interrupt toward the processor. Software sets the buffer's 64-bit base address and size and turns the unit on through a small register bus. As it drains records, software moves a consumer offset forward. The block owns the producer offset and compares it with the consumer offset to tell when the ring is empty or full.

Each accepted message becomes one write on a request/acknowledge memory channel. The record address is the base plus the producer offset. The low 32-bit word of the record carries the message data, and the other 96 bits are all ones. The producer offset moves forward only once memory has acknowledged the record, so software never sees an offset that runs ahead of data in memory. When the ring fills, software chooses one of two policies: hold the sender off, or discard the message and latch a sticky overflow flag.

Top module: `msi_ring_writer`

## Requirements
- R1: After synchronous reset, the control register, base address, consumer offset and producer offset all read 0, and irq_out and mem_req are 0.
- R2: The register words sit at reg_addr 0 (control), 3 (base high 32 bits), 4 (base low 32 bits), 5 (consumer offset) and 6 (producer offset). reg_rdata shows the addressed word one clock after reg_addr is presented. Control reads back bits 0, 1, 3, 4, 5 and 9:8, and its other bits read 0. A write to address 6 is ignored.
- R3: The clock edge that accepts a message (msg_valid and msg_ready both high) sets mem_req, with mem_addr equal to base plus producer offset and mem_data equal to {96 ones, message word}. All three hold until mem_ack, and msg_ready is 0 while mem_req is high.
- R4: The producer offset does not change while a record waits for mem_ack. It rises by 16 at the edge where mem_req and mem_ack are both high.
- R5: Offsets stay 16-byte aligned. With a 32 KB ring, the record after offset 0x7FF0 goes to offset 0 (base address itself).
- R6: Control bits 9:8 hold n, which sets the ring size to 2^(15+n) bytes. A consumer-offset write is stored ANDed with (size-1) and with its low 4 bits cleared, so writing 0x3FFFF reads back 0x3FFF0 with n=3 and 0x7FF0 with n=0.
- R7: The ring is full when (producer+16) mod size equals the consumer offset. If control bits 0, 1 and 4 are all set and the ring is full, msg_ready is 0 and no record is written. Once the consumer offset moves, the held message is written.
- R8: If the ring is full, bits 0 and 1 are set and bit 4 is clear, each message is taken (msg_ready 1) and discarded without a memory write. The overflow flag (control bit 5) is then set and stays set until a control write with bit 5 equal to 1.
- R9: irq_out is registered. It equals control bit 3 AND (consumer offset != producer offset), and follows a change of either input one clock later.
- R10: With control bit 0 clear, messages are taken and discarded, with no memory write and no change to the producer offset.
- R11: With control bit 1 clear, there is no full check: a message is written even when the ring is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| msg_valid | input | 1 | Inbound message present |
| msg_data | input | 32 | Inbound message word |
| msg_ready | output | 1 | Block can take a message this cycle |
| mem_req | output | 1 | Record write request |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents |
| mem_ack | input | 1 | Memory has taken the record |
| irq_out | output | 1 | Level interrupt to the processor |

## Verification
All inputs are driven on the falling edge, and every check samples on a later falling edge. A record request is visible at the first falling edge after the accepting rising edge. The new producer offset is visible after the acknowledging edge, and a register read returns one edge after its address. irq_out is checked one extra falling edge after the offset or control change that drives it, because it passes through one more register. Back-pressure and discard cases are observed by holding msg_valid for several cycles, then reading the producer offset and the overflow bit back over the register bus.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_BASE_HI = 3'd3;
  localparam logic [2:0] RA_BASE_LO = 3'd4;
  localparam logic [2:0] RA_RD_OFF  = 3'd5;
  localparam logic [2:0] RA_WR_OFF  = 3'd6;

  localparam int CB_ENABLE   = 0;
  localparam int CB_FULL_DET = 1;
  localparam int CB_IRQ_EN   = 3;
  localparam int CB_STOP     = 4;
  localparam int CB_OVF      = 5;
  localparam int CB_SIZE_LO  = 8;

  typedef struct packed {
    logic [1:0] size_sel;
    logic       stop_on_full;
    logic       irq_en;
    logic       full_det;
    logic       enable;
  } ring_cfg_t;

  typedef enum logic {EMIT_IDLE, EMIT_BUSY} emit_state_t;

endpackage

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
  import msi_ring_pkg::*;
#(
  parameter int OFF_W     = 18,
  parameter int MIN_SHIFT = 15,
  parameter int REC_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size_sel,
  input  logic             advance,
  input  logic [OFF_W-1:0] rd_off,
  output logic [OFF_W-1:0] wr_off,
  output logic [OFF_W-1:0] size_mask,
  output logic             full
);

  localparam logic [OFF_W-1:0] STEP =
    {{(OFF_W-REC_SHIFT-1){1'b0}}, 1'b1, {REC_SHIFT{1'b0}}};

  logic [OFF_W-1:0] wr_next;

  // bits between the record size and the selected ring size
  always_comb begin
    for (int i = 0; i < OFF_W; i++) begin
      size_mask[i] = (i >= REC_SHIFT) && (i < MIN_SHIFT + int'(size_sel));
    end
  end

  assign wr_next = (wr_off + STEP) & size_mask;
  assign full    = (wr_next == (rd_off & size_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_off <= '0;
    end else if (advance) begin
      wr_off <= wr_next;
    end
  end

endmodule

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr_en,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [OFF_W-1:0] size_mask,
  input  logic [OFF_W-1:0] wr_off,
  input  logic             set_ovf,
  output ring_cfg_t        cfg,
  output logic [63:0]      base_addr,
  output logic [OFF_W-1:0] rd_off
);

  logic        ovf;
  logic [31:0] ctrl_view;

  assign ctrl_view = {22'd0, cfg.size_sel, 2'b00, ovf, cfg.stop_on_full,
                      cfg.irq_en, 1'b0, cfg.full_det, cfg.enable};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      base_addr <= '0;
      rd_off    <= '0;
    end else if (reg_wr_en) begin
      case (reg_addr)
        RA_CTRL: begin
          cfg.enable       <= reg_wdata[CB_ENABLE];
          cfg.full_det     <= reg_wdata[CB_FULL_DET];
          cfg.irq_en       <= reg_wdata[CB_IRQ_EN];
          cfg.stop_on_full <= reg_wdata[CB_STOP];
          cfg.size_sel     <= reg_wdata[CB_SIZE_LO+1:CB_SIZE_LO];
        end
        RA_BASE_HI: base_addr[63:32] <= reg_wdata;
        RA_BASE_LO: base_addr[31:0]  <= reg_wdata;
        RA_RD_OFF:  rd_off <= reg_wdata[OFF_W-1:0] & size_mask;
        default: ;
      endcase
    end
  end

  // sticky overflow: a new drop wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
    end else if (set_ovf) begin
      ovf <= 1'b1;
    end else if (reg_wr_en && reg_addr == RA_CTRL && reg_wdata[CB_OVF]) begin
      ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL:    reg_rdata <= ctrl_view;
        RA_BASE_HI: reg_rdata <= base_addr[63:32];
        RA_BASE_LO: reg_rdata <= base_addr[31:0];
        RA_RD_OFF:  reg_rdata <= 32'(rd_off);
        RA_WR_OFF:  reg_rdata <= 32'(wr_off);
        default:    reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/msi_ring_emit.sv
module msi_ring_emit
  import msi_ring_pkg::*;
#(
  parameter int OFF_W  = 18,
  parameter int MSG_W  = 32,
  parameter int ADDR_W = 64,
  parameter int REC_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  ring_cfg_t         cfg,
  input  logic              full,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic              msg_valid,
  input  logic [MSG_W-1:0]  msg_data,
  output logic              msg_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              mem_ack,
  output logic              advance,
  output logic              set_ovf
);

  localparam int PAD_W = REC_W - MSG_W;

  emit_state_t state;
  logic        blocked;
  logic        take;
  logic        write_it;

  assign blocked   = cfg.full_det & full;
  assign msg_ready = (state == EMIT_IDLE) &
                     !(cfg.enable & blocked & cfg.stop_on_full);
  assign take      = msg_valid & msg_ready;
  assign write_it  = take & cfg.enable & !blocked;
  assign set_ovf   = take & cfg.enable & blocked;
  assign mem_req   = (state == EMIT_BUSY);
  assign advance   = mem_req & mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= EMIT_IDLE;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      case (state)
        EMIT_IDLE: if (write_it) begin
          state    <= EMIT_BUSY;
          mem_addr <= base_addr + {{(ADDR_W-OFF_W){1'b0}}, wr_off};
          mem_data <= {{PAD_W{1'b1}}, msg_data};
        end
        EMIT_BUSY: if (mem_ack) state <= EMIT_IDLE;
        default: state <= EMIT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
#(
  parameter int MIN_SHIFT  = 15,
  parameter int SIZE_CODES = 4,
  parameter int REC_SHIFT  = 4,
  parameter int MSG_W      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr_en,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          msg_valid,
  input  logic [MSG_W-1:0] msg_data,
  output logic          msg_ready,
  output logic          mem_req,
  output logic [63:0]   mem_addr,
  output logic [(8<<REC_SHIFT)-1:0] mem_data,
  input  logic          mem_ack,
  output logic          irq_out
);

  localparam int OFF_W  = MIN_SHIFT + SIZE_CODES - 1;
  localparam int REC_W  = 8 << REC_SHIFT;
  localparam int ADDR_W = 64;

  ring_cfg_t        cfg;
  logic [63:0]      base_addr;
  logic [OFF_W-1:0] rd_off;
  logic [OFF_W-1:0] wr_off;
  logic [OFF_W-1:0] size_mask;
  logic             full;
  logic             advance;
  logic             set_ovf;

  msi_ring_ptr #(.OFF_W(OFF_W), .MIN_SHIFT(MIN_SHIFT), .REC_SHIFT(REC_SHIFT)) u_ptr (
    .clk(clk), .rst(rst), .size_sel(cfg.size_sel), .advance(advance),
    .rd_off(rd_off), .wr_off(wr_off), .size_mask(size_mask), .full(full)
  );

  msi_ring_regs #(.OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .size_mask(size_mask),
    .wr_off(wr_off), .set_ovf(set_ovf), .cfg(cfg), .base_addr(base_addr),
    .rd_off(rd_off)
  );

  msi_ring_emit #(.OFF_W(OFF_W), .MSG_W(MSG_W), .ADDR_W(ADDR_W), .REC_W(REC_W)) u_emit (
    .clk(clk), .rst(rst), .cfg(cfg), .full(full), .base_addr(base_addr),
    .wr_off(wr_off), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_ready(msg_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack), .advance(advance),
    .set_ovf(set_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
    end else begin
      irq_out <= cfg.irq_en & (rd_off != wr_off);
    end
  end

endmodule

// File: rtl/msi_ring_checker.sv
module msi_ring_checker #(
  parameter int OFF_W     = 18,
  parameter int REC_W     = 128,
  parameter int MSG_W     = 32,
  parameter int REC_SHIFT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_ready,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [63:0]      mem_addr,
  input logic [REC_W-1:0] mem_data,
  input logic [OFF_W-1:0] wr_off,
  input logic             cfg_enable,
  input logic             cfg_full_det,
  input logic             cfg_stop,
  input logic             cfg_irq_en,
  input logic             full,
  input logic             irq_out
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));

  // R3
  pad_ones_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (&mem_data[REC_W-1:MSG_W]));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !msg_ready);

  // R4
  wr_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_off != $past(wr_off)) |-> $past(mem_req && mem_ack));

  // R5
  wr_align_chk: assert property (@(posedge clk) disable iff (rst)
    wr_off[REC_SHIFT-1:0] == '0);

  // R7
  stop_full_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_enable && cfg_full_det && cfg_stop && full |-> !msg_ready);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_irq_en |=> !irq_out);

endmodule

bind msi_ring_writer msi_ring_checker #(
  .OFF_W(OFF_W), .REC_W(REC_W), .MSG_W(MSG_W), .REC_SHIFT(REC_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .msg_ready(msg_ready), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data),
  .wr_off(wr_off), .cfg_enable(cfg.enable), .cfg_full_det(cfg.full_det),
  .cfg_stop(cfg.stop_on_full), .cfg_irq_en(cfg.irq_en), .full(full),
  .irq_out(irq_out)
);

// File: tb/test_msi_ring_writer.sv
module test_msi_ring_writer;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0001_2345_0000;
  localparam logic [95:0] PAD  = {96{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr_en = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid = 1'b0;
  logic [31:0]  msg_data = '0;
  logic         msg_ready;
  logic         mem_req;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         mem_ack;
  logic         irq_out;
  logic         auto_ack = 1'b1;
  logic         man_ack = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_wr = '0;

  assign mem_ack = auto_ack ? mem_req : man_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_ring_writer i_msi_ring_writer (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_ready(msg_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // returns on the falling edge after the accepting rising edge
  task automatic send_msg(input logic [31:0] d);
    msg_valid = 1'b1; msg_data = d;
    while (!msg_ready) @(negedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq_out", irq_out, 0);
    chk("R1 mem_req", mem_req, 0);
    reg_rd(3'd0, v); chk("R1 ctrl", v, 0);
    reg_rd(3'd4, v); chk("R1 base lo", v, 0);
    reg_rd(3'd5, v); chk("R1 rd_off", v, 0);
    reg_rd(3'd6, v); chk("R1 wr_off", v, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    reg_wr(3'd0, 32'hFFFF_FFFF);
    reg_rd(3'd0, v); chk("R2 ctrl readback", v, 32'h0000_031B);
    reg_wr(3'd5, 32'h0003_FFFF);
    reg_rd(3'd5, v); chk("R6 rd mask size 3", v, 32'h0003_FFF0);
    reg_wr(3'd0, 32'h0000_001B);
    reg_wr(3'd5, 32'h0003_FFFF);
    reg_rd(3'd5, v); chk("R6 rd mask size 0", v, 32'h0000_7FF0);
    reg_wr(3'd6, 32'h0000_1230);
    reg_rd(3'd6, v); chk("R2 wr_off read-only", v, 0);
    reg_wr(3'd3, BASE[63:32]);
    reg_wr(3'd4, BASE[31:0]);
    reg_rd(3'd3, v); chk("R2 base hi", v, BASE[63:32]);
    reg_rd(3'd4, v); chk("R2 base lo", v, BASE[31:0]);
    reg_wr(3'd5, 32'h0);
  endtask

  task automatic t_record;
    logic [31:0] v;
    auto_ack = 1'b0;
    chk("R3 ready idle", msg_ready, 1);
    send_msg(32'hABCD_0042);
    chk("R3 req set", mem_req, 1);
    chk("R3 addr", mem_addr, BASE);
    chk("R3 data", mem_data, {PAD, 32'hABCD_0042});
    repeat (3) @(negedge clk);
    chk("R3 req held", mem_req, 1);
    chk("R3 addr held", mem_addr, BASE);
    chk("R3 no ready busy", msg_ready, 0);
    reg_rd(3'd6, v); chk("R4 wr waits ack", v, 0);
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    chk("R3 req drops", mem_req, 0);
    reg_rd(3'd6, v); chk("R4 wr after ack", v, 32'h10);
    auto_ack = 1'b1;
    send_msg(32'h0000_BEEF);
    chk("R3 second addr", mem_addr, BASE + 64'h10);
    @(negedge clk);
    exp_wr = 32'h20;
  endtask

  task automatic t_irq;
    @(negedge clk);
    chk("R9 irq pending", irq_out, 1);
    reg_wr(3'd5, 32'h20);
    @(negedge clk);
    chk("R9 irq empty", irq_out, 0);
    reg_wr(3'd0, 32'h0000_0013);
    send_msg(32'h11);
    @(negedge clk); @(negedge clk);
    exp_wr = 32'h30;
    chk("R9 irq gated", irq_out, 0);
    reg_wr(3'd0, 32'h0000_001B);
    @(negedge clk);
    chk("R9 irq enabled", irq_out, 1);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    reg_wr(3'd0, 32'h0000_001A);
    chk("R10 ready when off", msg_ready, 1);
    send_msg(32'h77);
    chk("R10 no write", mem_req, 0);
    @(negedge clk);
    reg_rd(3'd6, v); chk("R10 wr unchanged", v, exp_wr);
    reg_wr(3'd0, 32'h0000_001B);
  endtask

  task automatic t_full_stop;
    logic [31:0] v;
    reg_wr(3'd5, exp_wr);
    for (int i = 0; i < 2047; i++) begin
      send_msg(32'(i));
      if (exp_wr == 32'h7FF0 || exp_wr == 32'h0)
        chk("R5 wrap addr", mem_addr, BASE + 64'(exp_wr));
      @(negedge clk);
      exp_wr = (exp_wr + 32'h10) & 32'h7FF0;
    end
    reg_rd(3'd6, v); chk("R5 wr wrapped", v, 32'h20);
    msg_valid = 1'b1; msg_data = 32'h5555;
    chk("R7 stop when full", msg_ready, 0);
    repeat (4) @(negedge clk);
    chk("R7 no write when full", mem_req, 0);
    reg_wr(3'd5, 32'h40);
    chk("R7 ready after drain", msg_ready, 1);
    @(negedge clk);
    msg_valid = 1'b0;
    chk("R7 held msg written", mem_addr, BASE + 64'h20);
    @(negedge clk);
    reg_rd(3'd6, v); chk("R7 wr after resume", v, 32'h30);
    exp_wr = 32'h30;
  endtask

  task automatic t_drop;
    logic [31:0] v;
    reg_wr(3'd0, 32'h0000_000B);
    chk("R8 ready when full", msg_ready, 1);
    send_msg(32'h66);
    chk("R8 dropped", mem_req, 0);
    send_msg(32'h67);
    chk("R8 dropped again", mem_req, 0);
    reg_rd(3'd0, v); chk("R8 overflow sticky", v, 32'h0000_002B);
    reg_rd(3'd6, v); chk("R8 wr unchanged", v, exp_wr);
    reg_wr(3'd0, 32'h0000_002B);
    reg_rd(3'd0, v); chk("R8 overflow cleared", v, 32'h0000_000B);
    reg_wr(3'd0, 32'h0000_0009);
    send_msg(32'hCAFE);
    chk("R11 written when full", mem_req, 1);
    chk("R11 addr", mem_addr, BASE + 64'h30);
    @(negedge clk);
    reg_rd(3'd6, v); chk("R11 wr advanced", v, 32'h40);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1-R11 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_record();
    t_irq();
    t_disabled();
    t_full_stop();
    t_drop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule